// File: doc/BRIEF.md
# Dual-Lane Shared-Coefficient FIR Engine

This block produces two FIR output samples per job. Two multiply-accumulate lanes run side by side and share a single coefficient stream. In every active cycle it reads three operands from three single-cycle read ports: a sample for lane X, a sample for lane Y, and one coefficient. It multiplies each sample by that common coefficient and updates the lane's own accumulator.

A job begins with a one-cycle start pulse. The pulse carries three base addresses (X data, Y data, coefficients) and a repeat value N. The first active cycle is a plain multiply that overwrites each accumulator with its product. After it come N+1 multiply-accumulate cycles, so a job covers N+2 taps. All three address pointers step up by one after each read. When the job ends, a one-cycle done pulse marks the two final sums, and these stay on the outputs until the next job starts.

The memories are external. The block drives the addresses and a read enable, and the data must come back combinationally in the same cycle.

Top module: `dual_mac_fir`

## Requirements
- R1: While reset is asserted, and after it is released, busy_o, done_o and rd_en_o are low and both accumulator outputs are zero.
- R2: A start_i pulse sampled while the block is idle latches the three bases and the repeat value. busy_o is high from the next cycle on.
- R3: In the first busy cycle the addresses equal the latched bases. At the end of that cycle each accumulator is overwritten with its own sample times the coefficient, and its earlier value is discarded.
- R4: busy_o stays high for exactly N+2 consecutive cycles: one initialising cycle and N+1 accumulate cycles.
- R5: Each of the three addresses increments by one after every busy cycle and wraps modulo 2^AW.
- R6: Both lanes use the same coefficient word in a given cycle. If the two samples are equal, the two accumulators change by the same amount.
- R7: done_o is high for exactly one cycle, the cycle right after the last busy cycle. In that cycle busy_o is low and each accumulator holds the sum over k = 0..N+1 of sample[base+k] * coef[cbase+k].
- R8: A start_i pulse sampled while busy_o is high is ignored. The bases, the count and the results of the running job are unaffected.
- R9: A start_i pulse sampled in the done cycle is accepted, so a new job follows with no idle cycle in between.
- R10: Samples and coefficients are 16-bit signed. The 40-bit signed accumulators give exact results for up to 257 taps of full-scale products (-32768 * -32768).
- R11: rd_en_o is high exactly in the busy cycles.
- R12: Outside busy cycles both accumulators keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Job start pulse |
| x_base_i | input | AW | Lane X data base address |
| y_base_i | input | AW | Lane Y data base address |
| c_base_i | input | AW | Coefficient base address |
| rpt_i | input | CNT_W | Repeat value N (N+1 accumulate cycles) |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_en_o | output | 1 | Operand read enable for all three ports |
| x_addr_o | output | AW | Lane X data read address |
| y_addr_o | output | AW | Lane Y data read address |
| c_addr_o | output | AW | Coefficient read address |
| x_data_i | input | DW | Lane X sample, same-cycle read data |
| y_data_i | input | DW | Lane Y sample, same-cycle read data |
| c_data_i | input | DW | Coefficient, same-cycle read data |
| acc_x_o | output | ACC_W | Lane X accumulator |
| acc_y_o | output | ACC_W | Lane Y accumulator |

## Verification
Completion and acceptance of a new job can fall in the same cycle. The bench raises start_i in the very cycle where done_o is high and judges the outcome two ways. First, the finished sums must still be readable in that done cycle. Second, the new job must begin at once with freshly latched bases, which the per-cycle reference model tracks on every clock. A second collision is a start pulse that lands mid-job with different bases. The model expects it to have no effect, and the final sums must match a software dot product taken over the original bases.

// File: rtl/fir2_pkg.sv
package fir2_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_INIT,
    ST_MAC,
    ST_DONE
  } fir2_state_e;

  localparam int unsigned NUM_PTR   = 3;
  localparam int unsigned PTR_X     = 0;
  localparam int unsigned PTR_Y     = 1;
  localparam int unsigned PTR_C     = 2;
  localparam int unsigned NUM_LANES = 2;
endpackage

// File: rtl/fir2_ctrl.sv
module fir2_ctrl
  import fir2_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] rpt_i,
  output logic             load_o,
  output logic             init_o,
  output logic             mac_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int unsigned RUN_W = CNT_W + 2;

  fir2_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             accept;

  assign accept = start_i && (state_q == ST_IDLE || state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: state_d = accept ? ST_INIT : ST_IDLE;
      ST_INIT:          state_d = ST_MAC;
      ST_MAC:           state_d = (cnt_q == '0) ? ST_DONE : ST_MAC;
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept)                                cnt_q <= rpt_i;
      else if (state_q == ST_MAC && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign load_o = accept;
  assign init_o = (state_q == ST_INIT);
  assign mac_o  = (state_q == ST_MAC);
  assign busy_o = init_o || mac_o;
  assign done_o = (state_q == ST_DONE);

  // checker-only run length tracking
  logic [RUN_W-1:0] run_len_q;
  logic [RUN_W-1:0] rpt_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_len_q  <= '0;
      rpt_seen_q <= '0;
    end else if (accept) begin
      run_len_q  <= '0;
      rpt_seen_q <= RUN_W'(rpt_i);
    end else if (busy_o) begin
      run_len_q  <= run_len_q + 1'b1;
    end
  end

  // R4
  run_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> run_len_q == rpt_seen_q + RUN_W'(2));
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R2
  start_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_o && cnt_q != '0 |=> mac_o);
endmodule

// File: rtl/fir2_ptr.sv
module fir2_ptr #(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          step_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (load_i) ptr_q <= base_i;
    else if (step_i) ptr_q <= ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;

  // R5
  post_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> ptr_o == $past(ptr_o) + 1'b1);
  // R8
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !step_i |=> $stable(ptr_o));
endmodule

// File: rtl/fir2_mac.sv
module fir2_mac #(
  parameter int unsigned DW    = 16,
  parameter int unsigned ACC_W = 40
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    init_i,
  input  logic                    mac_i,
  input  logic signed [DW-1:0]    sample_i,
  input  logic signed [DW-1:0]    coef_i,
  output logic signed [ACC_W-1:0] acc_o
);
  localparam int unsigned PROD_W = 2 * DW;
  localparam int unsigned EXT_W  = ACC_W - PROD_W;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;
  logic signed [ACC_W-1:0]  acc_q;

  assign prod     = sample_i * coef_i;
  assign prod_ext = {{EXT_W{prod[PROD_W-1]}}, prod};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (init_i) acc_q <= prod_ext;
    else if (mac_i)  acc_q <= acc_q + prod_ext;
  end

  assign acc_o = acc_q;

  // R12
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_i && !mac_i |=> $stable(acc_o));
endmodule

// File: rtl/dual_mac_fir.sv
module dual_mac_fir
  import fir2_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned AW    = 8,
  parameter int unsigned CNT_W = 8,
  parameter int unsigned ACC_W = 40
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [AW-1:0]           x_base_i,
  input  logic [AW-1:0]           y_base_i,
  input  logic [AW-1:0]           c_base_i,
  input  logic [CNT_W-1:0]        rpt_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    rd_en_o,
  output logic [AW-1:0]           x_addr_o,
  output logic [AW-1:0]           y_addr_o,
  output logic [AW-1:0]           c_addr_o,
  input  logic signed [DW-1:0]    x_data_i,
  input  logic signed [DW-1:0]    y_data_i,
  input  logic signed [DW-1:0]    c_data_i,
  output logic signed [ACC_W-1:0] acc_x_o,
  output logic signed [ACC_W-1:0] acc_y_o
);
  logic load, init_op, mac_op;
  logic [AW-1:0]           base_arr [NUM_PTR];
  logic [AW-1:0]           ptr_arr  [NUM_PTR];
  logic signed [DW-1:0]    smp_arr  [NUM_LANES];
  logic signed [ACC_W-1:0] acc_arr  [NUM_LANES];

  fir2_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .rpt_i  (rpt_i),
    .load_o (load),
    .init_o (init_op),
    .mac_o  (mac_op),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  assign base_arr[PTR_X] = x_base_i;
  assign base_arr[PTR_Y] = y_base_i;
  assign base_arr[PTR_C] = c_base_i;

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    fir2_ptr #(.AW(AW)) u_ptr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(load),
      .base_i(base_arr[i]),
      .step_i(busy_o),
      .ptr_o (ptr_arr[i])
    );
  end

  assign x_addr_o = ptr_arr[PTR_X];
  assign y_addr_o = ptr_arr[PTR_Y];
  assign c_addr_o = ptr_arr[PTR_C];
  assign rd_en_o  = busy_o;

  assign smp_arr[0] = x_data_i;
  assign smp_arr[1] = y_data_i;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    fir2_mac #(.DW(DW), .ACC_W(ACC_W)) u_mac (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .init_i  (init_op),
      .mac_i   (mac_op),
      .sample_i(smp_arr[l]),
      .coef_i  (c_data_i),
      .acc_o   (acc_arr[l])
    );
  end

  assign acc_x_o = acc_arr[0];
  assign acc_y_o = acc_arr[1];

  // R6
  shared_coef_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_op && x_data_i == y_data_i |=>
      (acc_x_o - acc_y_o) == $past(acc_x_o - acc_y_o));
  // R3
  init_equal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_op && x_data_i == y_data_i |=> acc_x_o == acc_y_o);
  // R5
  lockstep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (c_addr_o - x_addr_o) == $past(c_addr_o - x_addr_o));
  // R1
  idle_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rd_en_o);
endmodule

// File: tb/dual_mac_fir_bench.sv
module dual_mac_fir_bench;
  localparam int DW = 16, AW = 8, CNT_W = 8, ACC_W = 40;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] xb = '0, yb = '0, cb = '0;
  logic [CNT_W-1:0] rpt = '0;
  logic busy, done, rd_en;
  logic [AW-1:0] xa, ya, ca;
  logic signed [DW-1:0] xd, yd, cd;
  logic signed [ACC_W-1:0] accx, accy;

  logic signed [DW-1:0] xmem [DEPTH];
  logic signed [DW-1:0] ymem [DEPTH];
  logic signed [DW-1:0] cmem [DEPTH];

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  assign xd = xmem[xa];
  assign yd = ymem[ya];
  assign cd = cmem[ca];

  dual_mac_fir #(.DW(DW), .AW(AW), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_dual_mac_fir (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .x_base_i(xb), .y_base_i(yb), .c_base_i(cb), .rpt_i(rpt),
    .busy_o(busy), .done_o(done), .rd_en_o(rd_en),
    .x_addr_o(xa), .y_addr_o(ya), .c_addr_o(ca),
    .x_data_i(xd), .y_data_i(yd), .c_data_i(cd),
    .acc_x_o(accx), .acc_y_o(accy)
  );

  // behavioural reference: 0 idle, 1 init, 2 mac, 3 done
  int m_ph;
  int m_cnt;
  logic [AW-1:0] m_px, m_py, m_pc;
  longint m_ax, m_ay;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_px = '0; m_py = '0; m_pc = '0; m_ax = 0; m_ay = 0;
    end else begin
      case (m_ph)
        1, 2: begin
          if (m_ph == 1) begin
            m_ax = longint'(xmem[m_px]) * longint'(cmem[m_pc]);
            m_ay = longint'(ymem[m_py]) * longint'(cmem[m_pc]);
            m_ph = 2;
          end else begin
            m_ax += longint'(xmem[m_px]) * longint'(cmem[m_pc]);
            m_ay += longint'(ymem[m_py]) * longint'(cmem[m_pc]);
            if (m_cnt == 0) m_ph = 3;
            else m_cnt--;
          end
          m_px++; m_py++; m_pc++;
        end
        default: begin
          if (start) begin
            m_ph = 1; m_cnt = int'(rpt); m_px = xb; m_py = yb; m_pc = cb;
          end else m_ph = 0;
        end
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(busy == (m_ph == 1 || m_ph == 2), "R4", "busy", longint'(busy), longint'(m_ph == 1 || m_ph == 2));
      chk(done == (m_ph == 3), "R7", "done", longint'(done), longint'(m_ph == 3));
      chk(rd_en == busy, "R11", "rd_en", longint'(rd_en), longint'(busy));
      if (m_ph == 1 || m_ph == 2) begin
        chk(xa == m_px, "R5", "x_addr", longint'(xa), longint'(m_px));
        chk(ya == m_py, "R5", "y_addr", longint'(ya), longint'(m_py));
        chk(ca == m_pc, "R5", "c_addr", longint'(ca), longint'(m_pc));
      end
      chk(longint'(accx) == m_ax, "R6", "acc_x", longint'(accx), m_ax);
      chk(longint'(accy) == m_ay, "R6", "acc_y", longint'(accy), m_ay);
    end
  end

  function automatic longint dot(input logic [AW-1:0] db, input logic [AW-1:0] kb,
                                 input int taps, input bit lane_y);
    longint s = 0;
    for (int k = 0; k < taps; k++) begin
      logic [AW-1:0] da = db + AW'(k);
      logic [AW-1:0] ka = kb + AW'(k);
      s += longint'(lane_y ? ymem[da] : xmem[da]) * longint'(cmem[ka]);
    end
    return s;
  endfunction

  task automatic run_job(input logic [AW-1:0] x0, input logic [AW-1:0] y0,
                         input logic [AW-1:0] c0, input int n,
                         input bit poke, input bit chained, input bit chain_next);
    int busy_cnt = 0;
    int k = 0;
    if (!chained) @(negedge clk);
    xb = x0; yb = y0; cb = c0; rpt = CNT_W'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (chained) chk(busy == 1'b1, "R9", "busy after start in done cycle", longint'(busy), 1);
    else         chk(busy == 1'b1, "R2", "busy after start", longint'(busy), 1);
    chk(xa == x0 && ca == c0, "R3", "first addr equals base", longint'(xa), longint'(x0));
    while (!done) begin
      if (busy) busy_cnt++;
      if (poke && k == 1) begin
        start = 1'b1; xb = x0 + 8'd77; yb = y0 + 8'd5; cb = c0 + 8'd33; rpt = 8'd3;
      end else start = 1'b0;
      k++;
      if (k > 400) break;
      @(negedge clk);
    end
    start = 1'b0;
    chk(busy_cnt == n + 2, "R4", "busy cycle count", longint'(busy_cnt), longint'(n + 2));
    chk(done && !busy, "R7", "done without busy", longint'(done), 1);
    chk(longint'(accx) == dot(x0, c0, n + 2, 1'b0), poke ? "R8" : "R7", "acc_x dot",
        longint'(accx), dot(x0, c0, n + 2, 1'b0));
    chk(longint'(accy) == dot(y0, c0, n + 2, 1'b1), poke ? "R8" : "R7", "acc_y dot",
        longint'(accy), dot(y0, c0, n + 2, 1'b1));
    if (!chain_next) begin
      longint hx = longint'(accx);
      @(negedge clk);
      chk(longint'(accx) == hx && !done, "R12", "acc hold after done", longint'(accx), hx);
    end
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      xmem[i] = DW'($urandom);
      ymem[i] = DW'($urandom);
      cmem[i] = DW'($urandom);
    end
    repeat (3) @(negedge clk);
    chk(!busy && !done && !rd_en && accx == 0 && accy == 0, "R1", "reset outputs",
        longint'(busy) + longint'(done) + longint'(accx), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && accx == 0, "R1", "after release", longint'(busy), 0);

    run_job(8'd10, 8'd50, 8'd100, 6, 1'b0, 1'b0, 1'b0);
    run_job(8'd250, 8'd3, 8'd254, 0, 1'b0, 1'b0, 1'b0);
    run_job(8'd20, 8'd40, 8'd60, 9, 1'b1, 1'b0, 1'b0);
    run_job(8'd1, 8'd2, 8'd3, 4, 1'b0, 1'b0, 1'b1);
    run_job(8'd90, 8'd91, 8'd92, 5, 1'b0, 1'b1, 1'b0);
    for (int j = 0; j < 12; j++) begin
      run_job(AW'($urandom), AW'($urandom), AW'($urandom), int'($urandom_range(0, 40)),
              1'(j % 3 == 0), 1'b0, 1'b0);
    end
    // shared coefficient with equal samples, R6
    for (int i = 0; i < DEPTH; i++) ymem[i] = xmem[i];
    run_job(8'd30, 8'd30, 8'd7, 11, 1'b0, 1'b0, 1'b0);
    chk(accx == accy, "R6", "equal lanes", longint'(accx), longint'(accy));
    // full-scale, R10
    for (int i = 0; i < DEPTH; i++) begin
      xmem[i] = -16'sd32768; ymem[i] = -16'sd32768; cmem[i] = -16'sd32768;
    end
    run_job(8'd0, 8'd0, 8'd0, 255, 1'b0, 1'b0, 1'b0);
    chk(longint'(accx) == 64'sd257 * 64'sd1073741824, "R10", "full scale sum",
        longint'(accx), 64'sd257 * 64'sd1073741824);

    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule